// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block decides whether a clock-recovery oscillator runs close enough to its target frequency for the phase loop to take over. It counts edges of the divided oscillator clock over a gate window timed by the reference clock. It then forms the absolute difference between that count and the count a correctly tuned oscillator would give. Two thresholds act on that difference. The loss-of-lock flag clears only when the error is within 500 ppm. Once clear, it returns only when the error goes beyond 1000 ppm. Between those two limits the flag keeps its state.

One reference clock serves both line rates: the native rate and the 15/14 wrapped rate. The reference may be any of four frequencies, each a power-of-two multiple of 19.44 MHz. The gate window is lengthened by the same power of two, so every window lasts the same time and expects the same count. The oscillator is observed through a divide-by-8 clock.

The edge count crosses into the reference domain as a Gray-coded free-running value. A second output, derived from the flag, tells the analog loop which control path steers the oscillator. There is no data path, so there is no valid/ready interface; every pin is plain control or status. The select inputs are expected to be synchronous to the reference clock.

Top module: `freq_lock_det`

## Requirements
- R1: While reset is asserted and after it is released, loss_of_lock is 1 and freq_loop_sel is 1 until a gate window has been measured.
- R2: At the end of a window, a locked-out detector clears loss_of_lock when |measured - expected| is no larger than the 500 ppm count tolerance (floor(expected*500/1e6) = 4 by default).
- R3: At the end of a window, a locked detector sets loss_of_lock when |measured - expected| exceeds the 1000 ppm count tolerance (floor(expected*1000/1e6) = 8 by default).
- R4: An error between the two tolerances leaves loss_of_lock unchanged, whether it is currently 0 or 1.
- R5: ref_sel encodes the reference frequency as 19.44 MHz * 2^ref_sel (0 = 19.44, 1 = 38.88, 2 = 77.76, 3 = 155.52 MHz). The window is 512 * 2^ref_sel reference cycles, so a correctly tuned oscillator gives the same count for every code.
- R6: rate_sel = 0 expects 8192 divided-oscillator edges per window (2488.32 MHz / 8). rate_sel = 1 expects floor(8192*15/14) = 8777 (2666.06 MHz / 8).
- R7: freq_loop_sel is 1, selecting the frequency loop, whenever loss_of_lock is 1. It is 0, selecting the phase loop, whenever loss_of_lock is 0.
- R8: After a locked detector sees the error move beyond 1000 ppm, loss_of_lock rises within two windows plus 8 reference cycles. That is under 60 us for every reference code.
- R9: The flag follows repeated alternation between in-tolerance and out-of-tolerance frequency in both directions, and it never latches.
- R10: Any change of ref_sel or rate_sel sets loss_of_lock within 2 reference cycles and restarts the gate window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all decisions are made in this domain |
| vco_div_clk | input | 1 | Oscillator clock divided by 8 |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_sel | input | 2 | Reference frequency code (R5) |
| rate_sel | input | 1 | Line rate: 0 native, 1 wrapped 15/14 |
| loss_of_lock | output | 1 | Active-high loss-of-lock flag |
| freq_loop_sel | output | 1 | 1 = frequency loop steers the oscillator, 0 = phase loop |

## Verification
The bench parks the oscillator at 750 ppm, which lies inside the hysteresis band, starting once from lock and once from loss of lock. A detector with a single threshold would flip state in one of those two cases. It alternates between a tuned and a detuned oscillator and checks the flag each time, which exposes a flag that sticks high or low. It switches rate and reference codes while the oscillator is tuned and expects the flag to rise at once. The flag must then settle according to the new expected count and window length; a wrongly scaled window or a missing 15/14 factor leaves the detector unable to lock. The time from a large detuning to the flag rising is also measured against the two-window bound.

// File: rtl/fld_pkg.sv
`timescale 1ns/1ps
package fld_pkg;
  // Count tolerance for a ppm limit, rounded down.
  function automatic int unsigned ppm_count(input int unsigned cnt, input int unsigned ppm);
    longint unsigned prod;
    prod = longint'(cnt) * longint'(ppm);
    return int'(prod / 64'd1000000);
  endfunction
endpackage

// File: rtl/fld_vco_counter.sv
`timescale 1ns/1ps
// Free-running edge counter in the oscillator domain, published as Gray code.
module fld_vco_counter #(
  parameter int W = 16
) (
  input  logic         vco_clk,
  input  logic         rst_n,
  output logic [W-1:0] gray_o
);
  logic [1:0]   rst_pipe;
  logic [W-1:0] bin_q;
  logic [W-1:0] bin_nxt;

  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end

  assign bin_nxt = bin_q + W'(1);

  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else if (rst_pipe[1]) begin
      bin_q  <= bin_nxt;
      gray_o <= bin_nxt ^ (bin_nxt >> 1);
    end
  end
endmodule

// File: rtl/fld_gray_sync.sv
`timescale 1ns/1ps
// Brings a Gray count into the reference domain and converts it to binary.
module fld_gray_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] bin_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= gray_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  always_comb begin
    bin_c[W-1] = chain[STAGES-1][W-1];
    for (int i = W-2; i >= 0; i--) bin_c[i] = bin_c[i+1] ^ chain[STAGES-1][i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bin_o <= '0;
    else        bin_o <= bin_c;
  end
endmodule

// File: rtl/fld_gate_timer.sv
`timescale 1ns/1ps
// Gate window of (2^BASE_LOG2 << sel) reference cycles.
module fld_gate_timer #(
  parameter int BASE_LOG2 = 9,
  localparam int WIN_W    = BASE_LOG2 + 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       win_done
);
  logic [WIN_W-1:0] cnt_q;
  logic [WIN_W-1:0] load;

  always_comb load = (WIN_W'(1) << (BASE_LOG2 + int'(sel))) - WIN_W'(1);

  assign win_done = (cnt_q == '0) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (restart || cnt_q == '0)    cnt_q <= load;
    else                                cnt_q <= cnt_q - WIN_W'(1);
  end
endmodule

// File: rtl/fld_lock_decide.sv
`timescale 1ns/1ps
// Per-window error and hysteresis decision.
module fld_lock_decide #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         win_done,
  input  logic [W-1:0] cur_cnt,
  input  logic [W-1:0] exp_cnt,
  input  logic [W-1:0] tol_lock,
  input  logic [W-1:0] tol_loss,
  output logic         lol,
  output logic [W-1:0] err
);
  logic [W-1:0] prev_q;
  logic [W-1:0] meas;

  assign meas = cur_cnt - prev_q;
  assign err  = (meas >= exp_cnt) ? (meas - exp_cnt) : (exp_cnt - meas);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      lol    <= 1'b1;
    end else if (restart) begin
      prev_q <= cur_cnt;
      lol    <= 1'b1;
    end else if (win_done) begin
      prev_q <= cur_cnt;
      if (lol && err <= tol_lock)      lol <= 1'b0;
      else if (!lol && err > tol_loss) lol <= 1'b1;
    end
  end
endmodule

// File: rtl/freq_lock_det.sv
`timescale 1ns/1ps
module freq_lock_det #(
  parameter int BASE_LOG2   = 9,
  parameter int VDIV_LOG2   = 3,
  parameter int LOCK_PPM    = 500,
  parameter int LOSS_PPM    = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       ref_clk,
  input  logic       vco_div_clk,
  input  logic       rst_n,
  input  logic [1:0] ref_sel,
  input  logic       rate_sel,
  output logic       loss_of_lock,
  output logic       freq_loop_sel
);
  import fld_pkg::*;

  // Line rate / 19.44 MHz = 128 = 2^7.
  localparam int unsigned NATIVE_CNT = 1 << (BASE_LOG2 + 7 - VDIV_LOG2);
  localparam int unsigned WRAP_CNT   = (NATIVE_CNT * 15) / 14;
  localparam int CNT_W               = $clog2(WRAP_CNT * 2) + 1;

  logic [CNT_W-1:0] vco_gray;
  logic [CNT_W-1:0] cur_cnt;
  logic [CNT_W-1:0] exp_tab  [2];
  logic [CNT_W-1:0] lock_tab [2];
  logic [CNT_W-1:0] loss_tab [2];
  logic [CNT_W-1:0] exp_sel, tol_lock_sel, tol_loss_sel, err_abs;
  logic [1:0]       sel_q;
  logic             rate_q, init_q, restart, win_done;

  for (genvar r = 0; r < 2; r++) begin : g_rate
    localparam int unsigned EXP = (r == 0) ? NATIVE_CNT : WRAP_CNT;
    assign exp_tab[r]  = CNT_W'(EXP);
    assign lock_tab[r] = CNT_W'(ppm_count(EXP, LOCK_PPM));
    assign loss_tab[r] = CNT_W'(ppm_count(EXP, LOSS_PPM));
  end

  assign exp_sel      = exp_tab[rate_q];
  assign tol_lock_sel = lock_tab[rate_q];
  assign tol_loss_sel = loss_tab[rate_q];

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      rate_q <= 1'b0;
      init_q <= 1'b0;
    end else begin
      sel_q  <= ref_sel;
      rate_q <= rate_sel;
      init_q <= 1'b1;
    end
  end

  assign restart = !init_q || (ref_sel != sel_q) || (rate_sel != rate_q);

  fld_vco_counter #(.W(CNT_W)) u_cnt (
    .vco_clk (vco_div_clk),
    .rst_n   (rst_n),
    .gray_o  (vco_gray)
  );

  fld_gray_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (ref_clk),
    .rst_n  (rst_n),
    .gray_i (vco_gray),
    .bin_o  (cur_cnt)
  );

  fld_gate_timer #(.BASE_LOG2(BASE_LOG2)) u_gate (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .sel      (ref_sel),
    .win_done (win_done)
  );

  fld_lock_decide #(.W(CNT_W)) u_dec (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .win_done (win_done),
    .cur_cnt  (cur_cnt),
    .exp_cnt  (exp_sel),
    .tol_lock (tol_lock_sel),
    .tol_loss (tol_loss_sel),
    .lol      (loss_of_lock),
    .err      (err_abs)
  );

  assign freq_loop_sel = loss_of_lock;
endmodule

// File: rtl/fld_checker.sv
`timescale 1ns/1ps
module fld_checker #(
  parameter int W = 16
) (
  input logic         ref_clk,
  input logic         rst_n,
  input logic         restart,
  input logic         win_done,
  input logic         loss_of_lock,
  input logic [W-1:0] err,
  input logic [W-1:0] tol_lock,
  input logic [W-1:0] tol_loss
);
  // R2
  clear_in_band_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(loss_of_lock) |-> ($past(win_done) && ($past(err) <= $past(tol_lock))));

  // R4
  set_needs_cause_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(loss_of_lock) |-> ($past(restart) || ($past(win_done) && ($past(err) > $past(tol_loss)))));

  // R10
  restart_unlocks_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    restart |=> loss_of_lock);

  // R5
  window_spacing_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    win_done |=> !win_done);

  // R3
  far_error_unlocks_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (win_done && !loss_of_lock && (err > tol_loss)) |=> loss_of_lock);
endmodule

bind freq_lock_det fld_checker #(.W(CNT_W)) u_fld_chk (
  .ref_clk      (ref_clk),
  .rst_n        (rst_n),
  .restart      (restart),
  .win_done     (win_done),
  .loss_of_lock (loss_of_lock),
  .err          (err_abs),
  .tol_lock     (tol_lock_sel),
  .tol_loss     (tol_loss_sel)
);

// File: tb/test_freq_lock_det.sv
`timescale 1ns/1ps
module test_freq_lock_det;
  localparam real REF_PERIOD = 10.0;
  localparam int  BASE_WIN   = 512;
  localparam int  MAX_CYCLES = 200000;

  typedef struct { bit lol; string tag; } exp_t;

  logic ref_clk = 1'b0;
  logic vco_div_clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ref_sel = 2'd3;
  logic rate_sel = 1'b0;
  logic loss_of_lock, freq_loop_sel;

  real vco_half = 2.5;
  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done = 1'b0;
  exp_t sb_q[$];

  freq_lock_det i_freq_lock_det (
    .ref_clk       (ref_clk),
    .vco_div_clk   (vco_div_clk),
    .rst_n         (rst_n),
    .ref_sel       (ref_sel),
    .rate_sel      (rate_sel),
    .loss_of_lock  (loss_of_lock),
    .freq_loop_sel (freq_loop_sel)
  );

  always #(REF_PERIOD/2.0) ref_clk = ~ref_clk;
  always #(vco_half) vco_div_clk = ~vco_div_clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Oscillator offset in ppm for the current codes.
  task automatic set_vco(input real ppm);
    real ratio;
    ratio = 16.0 / real'(1 << ref_sel);
    if (rate_sel) ratio = ratio * 15.0 / 14.0;
    vco_half = REF_PERIOD / (2.0 * ratio * (1.0 + ppm * 1.0e-6));
  endtask

  task automatic settle();
    repeat (2 * (BASE_WIN << ref_sel) + 20) @(posedge ref_clk);
  endtask

  task automatic expect_lol(input bit lol, input string tag);
    exp_t e;
    e.lol = lol;
    e.tag = tag;
    sb_q.push_back(e);
    repeat (2) @(negedge ref_clk);
  endtask

  // Monitor: compares both outputs against each queued item.
  initial begin
    forever begin
      exp_t e;
      wait (sb_q.size() > 0);
      e = sb_q.pop_front();
      @(negedge ref_clk);
      check(loss_of_lock == e.lol, e.tag, int'(loss_of_lock), int'(e.lol));
      check(freq_loop_sel == e.lol, {e.tag, " R7 loop select"}, int'(freq_loop_sel), int'(e.lol));
    end
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge ref_clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int lat;
    set_vco(0.0);
    repeat (5) @(negedge ref_clk);
    expect_lol(1'b1, "R1 in reset");
    rst_n = 1'b1;
    repeat (20) @(negedge ref_clk);
    expect_lol(1'b1, "R1 after reset");

    settle(); expect_lol(1'b0, "R2 lock at 0 ppm");
    set_vco(750.0);   settle(); expect_lol(1'b0, "R4 hold locked +750");
    set_vco(-750.0);  settle(); expect_lol(1'b0, "R4 hold locked -750");
    set_vco(2000.0);  settle(); expect_lol(1'b1, "R3 lose at +2000");
    set_vco(750.0);   settle(); expect_lol(1'b1, "R4 hold unlocked +750");
    set_vco(0.0);     settle(); expect_lol(1'b0, "R2 relock");

    // R8 latency from a large step
    @(negedge ref_clk);
    set_vco(5000.0);
    lat = 0;
    while (!loss_of_lock && lat < 3 * 4096) begin
      @(negedge ref_clk);
      lat++;
    end
    check(lat <= 2 * 4096 + 8, "R8 assert latency", lat, 2 * 4096 + 8);

    // R9 repeated toggling
    for (int k = 0; k < 2; k++) begin
      set_vco(0.0);    settle(); expect_lol(1'b0, "R9 toggle lock");
      set_vco(-3000.0); settle(); expect_lol(1'b1, "R9 toggle unlock");
    end
    set_vco(0.0); settle(); expect_lol(1'b0, "R9 final lock");

    // R10 / R6: rate change
    rate_sel = 1'b1;
    repeat (3) @(negedge ref_clk);
    check(loss_of_lock == 1'b1, "R10 rate change", int'(loss_of_lock), 1);
    settle(); expect_lol(1'b1, "R6 native clock under wrapped rate");
    set_vco(0.0); settle(); expect_lol(1'b0, "R6 wrapped rate lock");
    set_vco(750.0); settle(); expect_lol(1'b0, "R6 wrapped rate hold");

    // R10 / R5: reference code changes
    rate_sel = 1'b0;
    ref_sel  = 2'd2;
    set_vco(0.0);
    repeat (3) @(negedge ref_clk);
    check(loss_of_lock == 1'b1, "R10 ref code change", int'(loss_of_lock), 1);
    settle(); expect_lol(1'b0, "R5 lock with code 2");
    ref_sel = 2'd1;
    set_vco(0.0);
    repeat (3) @(negedge ref_clk);
    check(loss_of_lock == 1'b1, "R10 ref code change to 1", int'(loss_of_lock), 1);
    settle(); expect_lol(1'b0, "R5 lock with code 1");
    vco_half = vco_half * 2.0;
    settle(); expect_lol(1'b1, "R5 half frequency with code 1");

    wait (sb_q.size() == 0);
    repeat (4) @(negedge ref_clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule